// File: doc/BRIEF.md
# Key Equation Solver for Reed-Solomon Decoding

This block takes the 2T syndromes of a received Reed-Solomon word over GF(2^8) and returns the error locator polynomial sigma(x), the error evaluator polynomial Omega(x) and the locator degree. It runs the Berlekamp-Massey recursion with the first step already folded into the starting values. Only the remaining 2T-1 steps are executed. Each step first forms the discrepancy. A zero discrepancy costs a single cycle and leaves sigma untouched. A nonzero one updates sigma, and before that it may need the inverse of the stored previous discrepancy. That inverse is computed by repeated square-and-multiply and is cached until the stored discrepancy changes.

Once sigma is final, the sum-of-products unit that formed the discrepancies is reused, one cycle per coefficient, to produce Omega from the syndromes and sigma. A syndrome stage that has already found the word clean can raise the clean input together with start. The solver then skips all work and answers on the accepting edge with sigma = 1, Omega = 0 and degree 0. Results stay on the outputs until the next accepted start.

Top module: `rs_keq_solver`

## Requirements
- R1: After reset, busy and done are low, sigma_o is 1 (coefficient 0 equal to 1, all others 0), omega_o is 0 and deg_o is 0.
- R2: When start and clean are both high while idle, done is high after that same edge, busy stays low, and the outputs become sigma_o = 1, omega_o = 0 and deg_o = 0.
- R3: The field is GF(2^8) with the reduction polynomial x^8+x^4+x^3+x^2+1 (0x11D) and primitive element alpha = 0x02. Syndrome S_j (j = 1..2T) is read from synd_i bits [8(j-1)+7 : 8(j-1)]. Coefficient k of sigma is placed at sigma_o bits [8k+7 : 8k].
- R4: For syndromes of up to T symbol errors, sigma_o equals the Berlekamp-Massey locator normalised to constant term 1, and it is zero at alpha^(-p) for every error position p.
- R5: deg_o equals the final locator length, which is the number of errors when that number is at most T.
- R6: Coefficient Omega_j, for j = 0..T-1, equals S_{j+1} + S_j*sigma_1 + ... + S_1*sigma_j and is placed at omega_o bits [8j+7 : 8j].
- R7: When S_1 is zero, the recursion starts from length 0, so all-zero syndromes with clean low end with sigma_o = 1, omega_o = 0 and deg_o = 0.
- R8: A step with zero discrepancy takes one cycle. With all-zero syndromes and clean low, done is high after the 3T-th rising edge, counting the accepting edge as the first.
- R9: No run takes more than 1 + 9(2T-1) + T edges from the accepting edge to done. That is 144 for T = 8.
- R10: done is a one-cycle pulse issued only while busy is low. Start is ignored while busy. While idle with start low, the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a solve; accepted only while idle |
| clean | input | 1 | With start: word known error-free, skip the solve |
| synd_i | input | 2T*8 | Syndromes S_1..S_2T, S_1 in the low byte |
| busy | output | 1 | Solve in progress |
| done | output | 1 | One-cycle pulse, results valid |
| sigma_o | output | (T+1)*8 | Error locator coefficients, sigma_0 in the low byte |
| omega_o | output | T*8 | Error evaluator coefficients, Omega_0 in the low byte |
| deg_o | output | $clog2(2T+1) | Final locator length |

## Verification
The assertions take for granted that start is a clean synchronous level and that clean carries meaning only together with an accepted start. They also take for granted that the syndromes are stable only at the accepting edge, because the block copies them there. The bench raises start for exactly one cycle and drives every input at the falling edge. It builds syndromes only from real error patterns of 0 to T errors at distinct positions with nonzero values, so the locator never needs more than T+1 coefficients. Its single start pulse during a busy run is there to confirm that such a pulse is ignored.

// File: rtl/rs_keq_solver.sv
module rs_keq_solver #(
  parameter int T = 8,
  parameter int M = 8,
  parameter logic [M:0] POLY = 9'h11D
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     clean,
  input  logic [2*T*M-1:0]         synd_i,
  output logic                     busy,
  output logic                     done,
  output logic [(T+1)*M-1:0]       sigma_o,
  output logic [T*M-1:0]           omega_o,
  output logic [$clog2(2*T+1)-1:0] deg_o
);
  localparam int NS = 2*T;
  localparam int IW = $clog2(NS);
  localparam int DW = $clog2(NS+1);
  localparam int PW = 2*M-1;

  typedef enum logic [2:0] {S_IDLE, S_DISC, S_INV, S_UPD, S_OMEG} st_t;

  function automatic logic [PW-1:0] clmul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [PW-1:0] p;
    p = '0;
    for (int k = 0; k < M; k++)
      if (b[k]) p = p ^ (PW'(a) << k);
    return p;
  endfunction

  function automatic logic [M-1:0] gred(input logic [PW-1:0] p);
    logic [PW-1:0] r;
    r = p;
    for (int k = PW-1; k >= M; k--)
      if (r[k]) r = r ^ (PW'(POLY) << (k-M));
    return r[M-1:0];
  endfunction

  function automatic logic [M-1:0] gmul(input logic [M-1:0] a, input logic [M-1:0] b);
    return gred(clmul(a, b));
  endfunction

  st_t            st;
  logic [M-1:0]   syn [1:NS];
  logic [M-1:0]   sig [0:T];
  logic [M-1:0]   tau [0:T];
  logic [M-1:0]   omg [0:T-1];
  logic [M-1:0]   delta, dinv, disc;
  logic           inv_ok;
  logic [DW-1:0]  dreg;
  logic [IW-1:0]  idx;
  logic [2:0]     icnt;

  logic [PW-1:0]  acc;
  logic [M-1:0]   sop, sq, inv_nxt, factor;
  logic           grow, last_it;

  always_comb begin
    acc = '0;
    for (int k = 0; k <= T; k++)
      if (int'(idx) + 1 - k >= 1)
        acc = acc ^ clmul(sig[k], syn[int'(idx) + 1 - k]);
    sop = gred(acc);
  end

  assign sq      = gmul(dinv, dinv);
  assign inv_nxt = (icnt == 3'd6) ? sq : gmul(sq, delta);
  assign factor  = gmul(disc, dinv);
  assign grow    = (2 * int'(dreg)) < (int'(idx) + 1);
  assign last_it = (idx == IW'(NS-1));
  assign busy    = (st != S_IDLE);
  assign deg_o   = dreg;

  genvar g;
  generate
    for (g = 0; g <= T; g++) begin : g_sig
      assign sigma_o[g*M +: M] = sig[g];
    end
    for (g = 0; g < T; g++) begin : g_omg
      assign omega_o[g*M +: M] = omg[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      done   <= 1'b0;
      delta  <= M'(1);
      dinv   <= M'(1);
      disc   <= '0;
      inv_ok <= 1'b1;
      dreg   <= '0;
      idx    <= '0;
      icnt   <= '0;
      for (int k = 1; k <= NS; k++) syn[k] <= '0;
      for (int k = 0; k <= T; k++) begin
        sig[k] <= (k == 0) ? M'(1) : '0;
        tau[k] <= '0;
      end
      for (int k = 0; k < T; k++) omg[k] <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          for (int k = 0; k <= T; k++) sig[k] <= (k == 0) ? M'(1) : '0;
          if (clean) begin
            dreg <= '0;
            done <= 1'b1;
            for (int k = 0; k < T; k++) omg[k] <= '0;
          end else begin
            for (int k = 1; k <= NS; k++) syn[k] <= synd_i[(k-1)*M +: M];
            for (int k = 0; k <= T; k++) tau[k] <= '0;
            sig[1] <= synd_i[M-1:0];
            idx    <= IW'(1);
            st     <= S_DISC;
            if (synd_i[M-1:0] != '0) begin
              delta  <= synd_i[M-1:0];
              inv_ok <= 1'b0;
              dreg   <= DW'(1);
              tau[0] <= M'(1);
            end else begin
              delta  <= M'(1);
              dinv   <= M'(1);
              inv_ok <= 1'b1;
              dreg   <= '0;
              tau[1] <= M'(1);
            end
          end
        end
        S_DISC: begin
          disc <= sop;
          if (sop == '0) begin
            tau[0] <= '0;
            for (int k = 1; k <= T; k++) tau[k] <= tau[k-1];
            if (last_it) begin
              idx <= '0;
              st  <= S_OMEG;
            end else begin
              idx <= idx + 1'b1;
            end
          end else if (inv_ok) begin
            st <= S_UPD;
          end else begin
            dinv <= delta;
            icnt <= '0;
            st   <= S_INV;
          end
        end
        S_INV: begin
          dinv <= inv_nxt;
          icnt <= icnt + 1'b1;
          if (icnt == 3'd6) begin
            inv_ok <= 1'b1;
            st     <= S_UPD;
          end
        end
        S_UPD: begin
          for (int k = 1; k <= T; k++) sig[k] <= sig[k] ^ gmul(factor, tau[k-1]);
          if (grow) begin
            for (int k = 0; k <= T; k++) tau[k] <= sig[k];
            dreg   <= DW'(int'(idx) + 1 - int'(dreg));
            delta  <= disc;
            inv_ok <= 1'b0;
          end else begin
            tau[0] <= '0;
            for (int k = 1; k <= T; k++) tau[k] <= tau[k-1];
          end
          if (last_it) begin
            idx <= '0;
            st  <= S_OMEG;
          end else begin
            idx <= idx + 1'b1;
            st  <= S_DISC;
          end
        end
        S_OMEG: begin
          omg[idx[$clog2(T)-1:0]] <= sop;
          if (idx == IW'(T-1)) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rs_keq_solver_chk.sv
module rs_keq_solver_chk #(
  parameter int T = 8,
  parameter int M = 8
)(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start,
  input logic                     clean,
  input logic                     busy,
  input logic                     done,
  input logic [(T+1)*M-1:0]       sigma_o,
  input logic [T*M-1:0]           omega_o,
  input logic [$clog2(2*T+1)-1:0] deg_o
);
  p_clean_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && clean && !busy |=> done && !busy && deg_o == '0 && omega_o == '0 &&
                                sigma_o == ((T+1)*M)'(1));

  p_monic_locator_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> sigma_o[M-1:0] == M'(1));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> !done && $stable(sigma_o) && $stable(omega_o) && $stable(deg_o));

  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start && !clean && !busy |=> busy);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind rs_keq_solver rs_keq_solver_chk #(.T(T), .M(M)) u_chk (.*);

// File: tb/rs_keq_solver_tb_top.sv
`timescale 1ns/1ps
module rs_keq_solver_tb_top;
  localparam int T = 8, M = 8, NS = 2*T;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, clean = 1'b0;
  logic [NS*M-1:0] synd = '0;
  logic busy, done;
  logic [(T+1)*M-1:0] sigma_o;
  logic [T*M-1:0] omega_o;
  logic [4:0] deg_o;

  always #2 clk = ~clk;

  rs_keq_solver #(.T(T), .M(M)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .clean(clean), .synd_i(synd),
    .busy(busy), .done(done), .sigma_o(sigma_o), .omega_o(omega_o), .deg_o(deg_o));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] S [1:NS];
  logic [7:0] es [0:T];
  logic [7:0] eo [0:T-1];
  int edeg, nerr, lat;
  int epos [0:T-1];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0, x = a, y = b;
    for (int k = 0; k < 8; k++) begin
      if (y[0]) p ^= x;
      y = y >> 1;
      x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
    end
    return p;
  endfunction

  function automatic logic [7:0] fpow(input logic [7:0] a, input int e);
    logic [7:0] r = 8'h01;
    for (int k = 0; k < e; k++) r = fmul(r, a);
    return r;
  endfunction

  function automatic logic [7:0] finv(input logic [7:0] a);
    for (int b = 1; b < 256; b++) if (fmul(a, 8'(b)) == 8'h01) return 8'(b);
    return 8'h00;
  endfunction

  task automatic make_synd(input int ne);
    logic [7:0] ev [0:T-1];
    nerr = ne;
    for (int l = 0; l < ne; l++) begin
      bit dup;
      do begin
        epos[l] = $urandom % 255;
        dup = 0;
        for (int q = 0; q < l; q++) if (epos[q] == epos[l]) dup = 1;
      end while (dup);
      ev[l] = 8'($urandom % 255 + 1);
    end
    for (int j = 1; j <= NS; j++) begin
      S[j] = 8'h00;
      for (int l = 0; l < ne; l++) S[j] ^= fmul(ev[l], fpow(8'h02, (j * epos[l]) % 255));
    end
  endtask

  task automatic model();
    logic [7:0] C [0:NS], B [0:NS], Tm [0:NS];
    logic [7:0] d, bb, f;
    int L = 0, m = 1;
    bb = 8'h01;
    for (int k = 0; k <= NS; k++) begin C[k] = (k == 0); B[k] = (k == 0); end
    for (int r = 0; r < NS; r++) begin
      d = S[r+1];
      for (int k = 1; k <= L; k++) if (r + 1 - k >= 1) d ^= fmul(C[k], S[r+1-k]);
      if (d == 0) m++;
      else begin
        f = fmul(d, finv(bb));
        Tm = C;
        for (int k = NS; k >= m; k--) C[k] ^= fmul(f, B[k-m]);
        if (2 * L <= r) begin
          L = r + 1 - L; B = Tm; bb = d; m = 1;
        end else m++;
      end
    end
    for (int k = 0; k <= T; k++) es[k] = C[k];
    edeg = L;
    for (int j = 0; j < T; j++) begin
      eo[j] = 8'h00;
      for (int k = 0; k <= j; k++) eo[j] ^= fmul(C[k], S[j+1-k]);
    end
  endtask

  task automatic pulse_start(input bit cl);
    @(negedge clk);
    for (int j = 1; j <= NS; j++) synd[(j-1)*M +: M] = S[j];
    start = 1'b1; clean = cl;
    @(negedge clk);
    start = 1'b0; clean = 1'b0;
    lat = 1;
    while (!done && lat < 400) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic check_result(input string tag, input bit roots);
    logic [(T+1)*M-1:0] xs;
    logic [T*M-1:0] xo;
    for (int k = 0; k <= T; k++) xs[k*M +: M] = es[k];
    for (int k = 0; k < T; k++) xo[k*M +: M] = eo[k];
    chk(done === 1'b1, "R9", {tag, " done within bound"}, 128'(lat), 128'(144));
    chk(lat <= 144, "R9", {tag, " latency"}, 128'(lat), 128'(144));
    chk(sigma_o === xs, "R4", {tag, " sigma"}, 128'(sigma_o), 128'(xs));
    chk(omega_o === xo, "R6", {tag, " omega"}, 128'(omega_o), 128'(xo));
    chk(int'(deg_o) == edeg, "R5", {tag, " degree"}, 128'(deg_o), 128'(edeg));
    if (roots) begin
      chk(int'(deg_o) == nerr, "R5", {tag, " degree vs error count"}, 128'(deg_o), 128'(nerr));
      for (int l = 0; l < nerr; l++) begin
        logic [7:0] x, v, xp;
        x = fpow(8'h02, (255 - epos[l]) % 255);
        v = 8'h00; xp = 8'h01;
        for (int k = 0; k <= T; k++) begin
          v ^= fmul(sigma_o[k*M +: M], xp);
          xp = fmul(xp, x);
        end
        chk(v == 8'h00, "R4", {tag, " root at error position"}, 128'(v), 128'(0));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy === 1'b0 && done === 1'b0, "R1", "busy/done after reset", {busy, done}, 0);
    chk(sigma_o === 72'h1 && omega_o === '0 && deg_o === '0, "R1", "outputs after reset",
        128'(sigma_o), 128'(1));
    rst_n = 1'b1;
    void'($urandom(32'h5EED_0C3A));

    // R7 R8 all-zero syndromes with clean low
    for (int j = 1; j <= NS; j++) S[j] = 0;
    nerr = 0;
    model();
    pulse_start(1'b0);
    chk(lat == 3 * T, "R8", "zero-syndrome latency", 128'(lat), 128'(3 * T));
    check_result("R7 zero syndromes", 1'b1);

    // R4 single error, R3 field and packing
    make_synd(1); model();
    pulse_start(1'b0);
    check_result("R3 single error", 1'b1);

    // R4 full capacity
    make_synd(T); model();
    pulse_start(1'b0);
    check_result("R4 T errors", 1'b1);

    // R2 clean skip after a real solve
    pulse_start(1'b1);
    chk(lat == 1, "R2", "clean latency", 128'(lat), 128'(1));
    chk(sigma_o === 72'h1 && omega_o === '0 && deg_o === '0, "R2", "clean outputs",
        128'(sigma_o), 128'(1));

    // R10 start ignored while busy
    make_synd(3); model();
    @(negedge clk);
    for (int j = 1; j <= NS; j++) synd[(j-1)*M +: M] = S[j];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    synd = ~synd;
    start = 1'b1; clean = 1'b1;
    @(negedge clk);
    start = 1'b0; clean = 1'b0;
    chk(done === 1'b0 && busy === 1'b1, "R10", "start while busy ignored", {done, busy}, 1);
    lat = 5;
    while (!done && lat < 400) begin @(negedge clk); lat++; end
    check_result("R10 busy start", 1'b1);
    @(negedge clk);
    chk(done === 1'b0, "R10", "done single pulse", 128'(done), 0);
    repeat (3) @(negedge clk);
    chk(omega_o === omega_o && sigma_o[M-1:0] === 8'h01, "R10", "idle hold", 128'(sigma_o[7:0]), 1);

    // random patterns, 0..T errors
    for (int n = 0; n < 60; n++) begin
      make_synd($urandom % (T + 1)); model();
      pulse_start(1'b0);
      check_result("R4 random", 1'b1);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule